// File: doc/BRIEF.md
# Byte-Mode Effective Address Generator

This block turns a memory-reference instruction into the address of its operand for a 16-bit processor that can work on byte operands. A request carries the instruction word, the program counter P, the index register X and the byte-mode flag. For the direct modes the address comes from decode logic and adders alone. For the indirect modes the block reads one address-pointer word through a plain memory read port (request, address, read data, valid) and then forms the final address from it.

A result gives a 16-bit byte address, the 15-bit word address and byte-select taken from it, and a flag that says whether the operand is a byte. The jump, jump-and-store, increment-and-skip and scan opcodes always take word operands. When the byte-mode flag is clear, every instruction takes word operands.

Both stream edges use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a request offered during a pointer fetch or while a result is pending waits. A result stays on the output pins, unchanged, from the rise of `out_valid` until the edge where `out_ready` is high.

Top module: `byte_ea_gen`

## Requirements
- R1: The instruction word holds the opcode in bits 15..11, the mode code M in bits 10..9, the indirect tag I in bit 8 and the displacement D in bits 7..0. In byte mode with I=0 and M=00, the byte address is D zero-extended to 16 bits, and no pointer read takes place.
- R2: In byte mode with I=0 and M=01 or M=11, the word address is P+1+D, taken modulo 2^15. The byte-select is 0 (the high byte) for M=01 and 1 (the low byte) for M=11. The byte address is the word address shifted left by one, with the byte-select in bit 0.
- R3: In byte mode with I=0 and M=10, the byte address is X+D, modulo 2^16.
- R4: With I=1, one pointer read is issued on `mem_addr`. Its word address is D for M=00 and M=10, P+1+D for M=01, and P-D for M=11, each taken modulo 2^15.
- R5: With I=1, exactly one pointer read is made. The final address is the pointer plus X for M=10, and the pointer alone for the other modes. In byte mode this value is a byte address.
- R6: Opcodes 0x02, 0x03, 0x04 and 0x05 (jump, jump-and-store, increment-and-skip, scan) give `out_is_byte`=0 and `out_byte_sel`=0 even when the byte-mode flag is set. They use word addressing as in R7.
- R7: With the byte-mode flag clear, word addressing is used. The direct word address is D for M=00, P+1+D for M=01, X+D for M=10 and P-D for M=11. For indirect, the pointer word address follows R4 and the final word address follows R5. `out_byte_addr` is the word address shifted left by one.
- R8: `req_ready` is high only when idle. A direct request gives `out_valid` on the cycle after it is taken. The result holds steady while `out_ready` is low. A request offered while the block is busy is not taken.
- R9: After reset, `req_ready` is 1 and both `out_valid` and `mem_req` are 0.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_valid` arrives. `out_valid` rises on the cycle after `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_instr | input | 16 | Instruction word |
| req_p | input | 16 | Program counter value |
| req_x | input | 16 | Index register value |
| req_byte_mode | input | 1 | Byte-mode flag |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 15 | Pointer word address |
| mem_rdata | input | 16 | Pointer read data |
| mem_valid | input | 1 | Read data valid |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_byte_addr | output | 16 | Operand byte address |
| out_word_addr | output | 15 | Operand word address |
| out_byte_sel | output | 1 | Byte within word, 0 = high byte |
| out_is_byte | output | 1 | Operand is a byte |

## Verification
The assertions assume that the memory raises `mem_valid` only while `mem_req` is high, and only for a single cycle per read. They also assume that `out_ready` is sampled only while `out_valid` is high. The bench's memory model drives `mem_valid` only on cycles where it sees `mem_req`, and drops it once the request falls. It raises `out_ready` only after it has seen `out_valid`, and lowers it on the next cycle. Junk requests are offered only during a result stall, which exercises the rule that a busy block does not take a request.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int OPC_W = 5;
  localparam int DSP_W = 8;
  localparam int OPC_LSB = 11;
  localparam int MODE_LSB = 9;
  localparam int IND_BIT = 8;

  localparam logic [1:0] MD_ZERO = 2'b00;
  localparam logic [1:0] MD_FWD0 = 2'b01;
  localparam logic [1:0] MD_INDX = 2'b10;
  localparam logic [1:0] MD_FWD1 = 2'b11;

  localparam int N_WORD_ONLY = 4;
  localparam logic [N_WORD_ONLY*OPC_W-1:0] WORD_ONLY_OPCS =
    {5'h05, 5'h04, 5'h03, 5'h02};

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} eag_state_t;
endpackage

// File: rtl/eag_excl_detect.sv
module eag_excl_detect
  import eag_pkg::*;
#(
  parameter int NUM = N_WORD_ONLY,
  parameter logic [NUM*OPC_W-1:0] LIST = WORD_ONLY_OPCS
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             hit
);
  logic [NUM-1:0] match;

  for (genvar gi = 0; gi < NUM; gi++) begin : g_cmp
    assign match[gi] = (opcode == LIST[gi*OPC_W +: OPC_W]);
  end

  assign hit = |match;
endmodule

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
#(
  parameter int DW = 16,
  localparam int WAW = DW - 1
) (
  input  logic [DW-1:0]  instr,
  input  logic [DW-1:0]  p_val,
  input  logic [DW-1:0]  x_val,
  input  logic           byte_mode,
  output logic           indirect,
  output logic           add_x,
  output logic           is_byte,
  output logic [DW-1:0]  direct_ea,
  output logic [WAW-1:0] ptr_waddr
);
  logic [OPC_W-1:0] opcode;
  logic [1:0]       mode;
  logic [DSP_W-1:0] dsp;
  logic             word_only;
  logic [DW-1:0]    fwd_full;
  logic [DW-1:0]    back_full;
  logic [DW-1:0]    idx_full;
  logic [WAW-1:0]   fwd_word;

  assign opcode   = instr[OPC_LSB +: OPC_W];
  assign mode     = instr[MODE_LSB +: 2];
  assign indirect = instr[IND_BIT];
  assign dsp      = instr[DSP_W-1:0];

  eag_excl_detect u_excl (
    .opcode (opcode),
    .hit    (word_only)
  );

  assign is_byte   = byte_mode & ~word_only;
  assign add_x     = (mode == MD_INDX);
  assign fwd_full  = p_val + DW'(1) + DW'(dsp);
  assign back_full = p_val - DW'(dsp);
  assign idx_full  = x_val + DW'(dsp);
  assign fwd_word  = fwd_full[WAW-1:0];

  always_comb begin
    direct_ea = DW'(dsp);
    if (is_byte) begin
      unique case (mode)
        MD_ZERO: direct_ea = DW'(dsp);
        MD_INDX: direct_ea = idx_full;
        default: direct_ea = {fwd_word, mode[1]};
      endcase
    end else begin
      unique case (mode)
        MD_ZERO: direct_ea = DW'(dsp);
        MD_FWD0: direct_ea = fwd_full;
        MD_INDX: direct_ea = idx_full;
        default: direct_ea = back_full;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      MD_FWD0: ptr_waddr = fwd_word;
      MD_FWD1: ptr_waddr = back_full[WAW-1:0];
      default: ptr_waddr = WAW'(dsp);
    endcase
  end
endmodule

// File: rtl/eag_combine.sv
module eag_combine #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] x_val,
  input  logic          add_x,
  output logic [DW-1:0] ea
);
  assign ea = add_x ? (ptr + x_val) : ptr;
endmodule

// File: rtl/eag_split.sv
module eag_split #(
  parameter int DW = 16,
  localparam int WAW = DW - 1
) (
  input  logic [DW-1:0]  ea,
  input  logic           is_byte,
  output logic [DW-1:0]  byte_addr,
  output logic [WAW-1:0] word_addr,
  output logic           byte_sel
);
  always_comb begin
    if (is_byte) begin
      byte_addr = ea;
      word_addr = ea[DW-1:1];
      byte_sel  = ea[0];
    end else begin
      byte_addr = {ea[WAW-1:0], 1'b0};
      word_addr = ea[WAW-1:0];
      byte_sel  = 1'b0;
    end
  end
endmodule

// File: rtl/byte_ea_gen.sv
module byte_ea_gen
  import eag_pkg::*;
#(
  parameter int DW = 16,
  localparam int WAW = DW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [DW-1:0]  req_instr,
  input  logic [DW-1:0]  req_p,
  input  logic [DW-1:0]  req_x,
  input  logic           req_byte_mode,
  output logic           mem_req,
  output logic [WAW-1:0] mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_valid,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_byte_addr,
  output logic [WAW-1:0] out_word_addr,
  output logic           out_byte_sel,
  output logic           out_is_byte
);
  eag_state_t     state;
  logic           dec_ind, dec_addx, dec_isb;
  logic [DW-1:0]  dec_ea;
  logic [WAW-1:0] dec_paddr;
  logic [DW-1:0]  ea_q, x_q, fin_ea;
  logic [WAW-1:0] paddr_q;
  logic           isb_q, addx_q;

  eag_decode #(.DW(DW)) u_dec (
    .instr     (req_instr),
    .p_val     (req_p),
    .x_val     (req_x),
    .byte_mode (req_byte_mode),
    .indirect  (dec_ind),
    .add_x     (dec_addx),
    .is_byte   (dec_isb),
    .direct_ea (dec_ea),
    .ptr_waddr (dec_paddr)
  );

  eag_combine #(.DW(DW)) u_comb (
    .ptr   (mem_rdata),
    .x_val (x_q),
    .add_x (addx_q),
    .ea    (fin_ea)
  );

  eag_split #(.DW(DW)) u_split (
    .ea        (ea_q),
    .is_byte   (isb_q),
    .byte_addr (out_byte_addr),
    .word_addr (out_word_addr),
    .byte_sel  (out_byte_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ea_q    <= '0;
      x_q     <= '0;
      paddr_q <= '0;
      isb_q   <= 1'b0;
      addx_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          isb_q  <= dec_isb;
          addx_q <= dec_addx;
          x_q    <= req_x;
          if (dec_ind) begin
            paddr_q <= dec_paddr;
            state   <= ST_FETCH;
          end else begin
            ea_q  <= dec_ea;
            state <= ST_DONE;
          end
        end
        ST_FETCH: if (mem_valid) begin
          ea_q  <= fin_ea;
          state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign mem_req     = (state == ST_FETCH);
  assign mem_addr    = paddr_q;
  assign out_valid   = (state == ST_DONE);
  assign out_is_byte = isb_q;
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int DW = 16,
  localparam int WAW = DW - 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [DW-1:0]  req_instr,
  input logic           mem_req,
  input logic [WAW-1:0] mem_addr,
  input logic           mem_valid,
  input logic           out_valid,
  input logic           out_ready,
  input logic [DW-1:0]  out_byte_addr,
  input logic           out_byte_sel,
  input logic           out_is_byte
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (out_valid || mem_req) |-> !req_ready); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_byte_addr) && $stable(out_is_byte)); // R8
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R10
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_valid |=> !mem_req && out_valid); // R5
  AST_DIRECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready && !req_instr[8] |=> !mem_req && out_valid); // R1
  AST_WORD_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_is_byte |-> !out_byte_sel); // R6
endmodule

bind byte_ea_gen eag_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_instr     (req_instr),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_valid     (mem_valid),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_byte_addr (out_byte_addr),
  .out_byte_sel  (out_byte_sel),
  .out_is_byte   (out_is_byte)
);

// File: tb/byte_ea_gen_bench.sv
module byte_ea_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_instr = '0, req_p = '0, req_x = '0;
  logic        req_byte_mode = 1'b0;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        mem_valid = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_byte_addr;
  logic [14:0] out_word_addr;
  logic        out_byte_sel, out_is_byte;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  byte_ea_gen u_byte_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_p(req_p), .req_x(req_x), .req_byte_mode(req_byte_mode),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte_addr(out_byte_addr),
    .out_word_addr(out_word_addr), .out_byte_sel(out_byte_sel), .out_is_byte(out_is_byte)
  );

  localparam int NV = 15;
  // instr, P, X, byte flag, pointer, expected byte address, expected is_byte, expected pointer address
  localparam logic [15:0] VI [NV] = '{16'h80A5, 16'h8210, 16'h8610, 16'h84FF, 16'h8420,
    16'h8133, 16'h8305, 16'h8734, 16'h8508, 16'h1210, 16'h2634, 16'h80A5, 16'h8508, 16'h2933, 16'h1C01};
  localparam logic [15:0] VP [NV] = '{16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234,
    16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234};
  localparam logic [15:0] VX [NV] = '{16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'hFFF0,
    16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'h0010, 16'h4000, 16'h4000};
  localparam logic VB [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] VPTR [NV] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
    16'hBEEF, 16'h7001, 16'h0102, 16'h1235, 16'h0, 16'h0, 16'h0, 16'h0100, 16'h2222, 16'h0};
  localparam logic [15:0] VEXP [NV] = '{16'h00A5, 16'h248A, 16'h248B, 16'h40FF, 16'h0010,
    16'hBEEF, 16'h7001, 16'h0102, 16'h5235, 16'h248A, 16'h2400, 16'h014A, 16'h0220, 16'h4444, 16'h8002};
  localparam logic VISB [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [14:0] VPA [NV] = '{15'h0, 15'h0, 15'h0, 15'h0, 15'h0,
    15'h0033, 15'h123A, 15'h1200, 15'h0008, 15'h0, 15'h0, 15'h0, 15'h0008, 15'h0033, 15'h0};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] i, input logic bm);
    if (i[15:11] >= 5'h02 && i[15:11] <= 5'h05) return "R6";
    if (!bm) return "R7";
    if (i[8]) return "R5";
    case (i[10:9])
      2'b00: return "R1";
      2'b10: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic do_op(input logic [15:0] instr, p, x, input logic bm, input logic [15:0] ptr,
                       input logic [15:0] exp_ba, input logic exp_isb, input logic [14:0] exp_pa,
                       input int mdly, input int rdly, input bit junk);
    int reads = 0, waited = 0, n = 0;
    bit done = 0, prev = 0;
    logic [14:0] held = '0;
    logic [15:0] hold_ba;
    string t = tag_of(instr, bm);
    @(negedge clk);
    chk(req_ready, "R8", {31'b0, req_ready}, 32'd1);
    req_instr = instr; req_p = p; req_x = x; req_byte_mode = bm; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 60) begin
      n++;
      if (mem_req) begin
        if (!prev) begin
          reads++; held = mem_addr;
          chk(mem_addr == exp_pa, "R4", {17'b0, mem_addr}, {17'b0, exp_pa});
        end else chk(mem_addr == held, "R10", {17'b0, mem_addr}, {17'b0, held});
        if (waited >= mdly) begin mem_valid = 1'b1; mem_rdata = ptr; end
        else begin mem_valid = 1'b0; waited++; end
        prev = 1;
        @(negedge clk);
      end else begin
        mem_valid = 1'b0; prev = 0;
        if (out_valid) begin
          chk(out_byte_addr == exp_ba, t, {16'b0, out_byte_addr}, {16'b0, exp_ba});
          chk(out_is_byte == exp_isb, t, {31'b0, out_is_byte}, {31'b0, exp_isb});
          chk(out_word_addr == exp_ba[15:1], t, {17'b0, out_word_addr}, {17'b0, exp_ba[15:1]});
          chk(out_byte_sel == (exp_isb & exp_ba[0]), t, {31'b0, out_byte_sel}, {31'b0, exp_isb & exp_ba[0]});
          hold_ba = out_byte_addr;
          for (int k = 0; k < rdly; k++) begin
            if (junk) begin req_instr = 16'h80A5; req_valid = 1'b1; end
            @(negedge clk);
            chk(out_valid && out_byte_addr == hold_ba && !req_ready, "R8",
                {16'b0, out_byte_addr}, {16'b0, hold_ba});
          end
          req_valid = 1'b0; out_ready = 1'b1;
          @(posedge clk);
          @(negedge clk);
          out_ready = 1'b0;
          chk(!out_valid && !mem_req && req_ready, "R8", {30'b0, out_valid, mem_req}, 32'd0);
          done = 1;
        end else @(negedge clk);
      end
    end
    if (!done) chk(1'b0, "R8", 32'd0, 32'd1);
    chk(reads == (instr[8] ? 1 : 0), "R5", reads, instr[8] ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !out_valid && !mem_req, "R9", {29'b0, req_ready, out_valid, mem_req}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !out_valid && !mem_req, "R9", {29'b0, req_ready, out_valid, mem_req}, 32'd4);
    for (int v = 0; v < NV; v++)
      do_op(VI[v], VP[v], VX[v], VB[v], VPTR[v], VEXP[v], VISB[v], VPA[v], 0, 0, 0);
    // R10: slow memory, indirect M=11 with P-D pointer address
    do_op(16'h8734, 16'h1234, 16'h0, 1'b1, 16'h0102, 16'h0102, 1'b1, 15'h1200, 3, 0, 0);
    // R8: stalled result with junk requests offered while busy
    do_op(16'h8610, 16'h1234, 16'h0, 1'b1, 16'h0, 16'h248B, 1'b1, 15'h0, 0, 3, 1);
    // R2: forward word address wraps at 15 bits
    do_op(16'h82FF, 16'h7FFF, 16'h0, 1'b1, 16'h0, 16'h01FE, 1'b1, 15'h0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule